// File: doc/BRIEF.md
# Instruction-Fetch Breakpoint Unit

This block watches the processor's bus and raises a user break request when a bus cycle meets a programmed address and cycle condition. Software writes a 32-bit break address as two 16-bit halves and a qualifier word. The qualifier enables requester (CPU or peripheral), cycle kind (instruction fetch or data access) and direction (read or write). A 32-bit on-chip fetch carries two 16-bit instructions, and the break address can name either one of them.

An instruction-fetch match does not stop anything at the bus. It arms a target instruction address. The break is decided later, when the CPU's instruction-step interface reaches that address. If interrupts can be accepted at that boundary, the break is taken before the instruction runs and the saved PC is the target address. If the target sits in a delay slot or follows an interrupt-inhibiting instruction, it executes. The break then waits for the next step that can accept interrupts, lets that instruction complete, and saves the address that follows it. A data-access match waits for the next interruptible step boundary and saves that step's address.

The controller is a five-state machine:

- **IDLE**: nothing armed.
- **ARMED**: a fetch target is held.
- **DEFER**: a fetch break is waiting past a non-interruptible instruction.
- **DATAW**: a data break is waiting.
- **PEND**: a request has been raised and not yet taken.

The transitions are:

- **IDLE→ARMED** on a fetch hit.
- **IDLE→DATAW** on a data hit.
- **ARMED→PEND** when the target steps at an interruptible boundary.
- **ARMED→DEFER** when the target steps at a blocked boundary.
- **DEFER→PEND** on the next interruptible step.
- **DATAW→PEND** on the next interruptible step.
- **PEND→IDLE** on the take strobe.

Top module: `fetch_break_unit`

## Requirements
- R1: After reset, `brk_req` and `brk_pend` are 0 and `saved_pc` is 0. All qualifier enables are cleared, so no bus cycle can cause a break until the qualifier is written.
- R2: A config write with `cfg_sel`=0 loads the upper 16 address bits, `cfg_sel`=1 loads the lower 16, and `cfg_sel`=2 loads the qualifier from `cfg_wdata[5:0]`. A write takes effect for bus cycles in later clocks.
- R3: The qualifier bits are: bit0 CPU requester, bit1 peripheral requester, bit2 fetch, bit3 data, bit4 read, bit5 write. A valid bus cycle hits only if the bits for its requester, kind and direction are all set and its address matches.
- R4: For a wide fetch (`bus_wide`=1), addresses match on bits 31:2. The armed target is the slot chosen by break-address bit 1, so naming the second instruction breaks only when that instruction steps, after the first has stepped.
- R5: For a narrow fetch, addresses match on bits 31:1. Bit 0 of the break address is ignored.
- R6: When the armed target steps with `step_intr_ok`=1, a break is raised and `saved_pc` equals the target address.
- R7: When the target steps with `step_intr_ok`=0, no break is raised at that step. The break is raised at the next step with `step_intr_ok`=1, and `saved_pc` equals that step's `step_next_pc`.
- R8: After a data hit, the break is raised at the next step with `step_intr_ok`=1, and `saved_pc` equals that step's `step_pc`.
- R9: `brk_req` is high for exactly one cycle, the cycle after the deciding step, and `brk_pend` rises in that same cycle.
- R10: `brk_pend` holds until `brk_take` is sampled high. `brk_take` while not pending has no effect. Bus hits while pending are ignored.
- R11: `saved_pc` is stable for as long as `brk_pend` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_we | input | 1 | Config write strobe |
| cfg_sel | input | 2 | Config target: 0 address high, 1 address low, 2 qualifier |
| cfg_wdata | input | 16 | Config write data |
| bus_valid | input | 1 | Bus cycle present |
| bus_addr | input | 32 | Bus cycle address |
| bus_periph | input | 1 | 1 = peripheral requester, 0 = CPU |
| bus_fetch | input | 1 | 1 = instruction fetch, 0 = data access |
| bus_write | input | 1 | 1 = write, 0 = read |
| bus_wide | input | 1 | Fetch delivers two 16-bit instructions |
| step_valid | input | 1 | An instruction boundary is reached |
| step_pc | input | 32 | Address of the instruction at this boundary |
| step_next_pc | input | 32 | Address following that instruction |
| step_intr_ok | input | 1 | Interrupts may be accepted at this boundary |
| brk_take | input | 1 | Break has been accepted by the exception logic |
| brk_req | output | 1 | One-cycle break request pulse |
| brk_pend | output | 1 | Break raised and not yet taken |
| saved_pc | output | 32 | PC value to save, valid while pending |

## Verification
A wrong controller state shows at the ports within one step: the break either appears at a step that should not raise it or fails to appear at the deciding step. Checks are made every cycle, so either error is seen in the cycle after that step. A wrong target or a wrong saved-PC choice shows as a `saved_pc` mismatch in the first pending cycle. A stuck pending state shows as `brk_pend` remaining high the cycle after `brk_take`.

// File: rtl/fbu_pkg.sv
package fbu_pkg;
    localparam int Q_CPU   = 0;
    localparam int Q_PER   = 1;
    localparam int Q_FETCH = 2;
    localparam int Q_DATA  = 3;
    localparam int Q_RD    = 4;
    localparam int Q_WR    = 5;
    localparam int QW      = 6;

    localparam logic [1:0] SEL_HI   = 2'd0;
    localparam logic [1:0] SEL_LO   = 2'd1;
    localparam logic [1:0] SEL_QUAL = 2'd2;

    typedef enum logic [2:0] {
        FB_IDLE  = 3'd0,
        FB_ARMED = 3'd1,
        FB_DEFER = 3'd2,
        FB_DATAW = 3'd3,
        FB_PEND  = 3'd4
    } fb_state_e;
endpackage

// File: rtl/fbu_regs.sv
module fbu_regs
    import fbu_pkg::*;
#(
    parameter int AW = 32
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  we,
    input  logic [1:0]            sel,
    input  logic [AW/2-1:0]       wdata,
    output logic [AW-1:0]         brk_addr,
    output logic [QW-1:0]         qual
);
    localparam int HW = AW / 2;

    logic unused_wdata_hi;
    assign unused_wdata_hi = ^wdata[HW-1:QW];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            brk_addr <= '0;
            qual     <= '0;
        end else if (we) begin
            case (sel)
                SEL_HI:   brk_addr[AW-1:HW] <= wdata;
                SEL_LO:   brk_addr[HW-1:0]  <= wdata;
                SEL_QUAL: qual              <= wdata[QW-1:0];
                default: ;
            endcase
        end
    end
endmodule

// File: rtl/fbu_match.sv
module fbu_match
    import fbu_pkg::*;
#(
    parameter int AW = 32
) (
    input  logic [AW-1:0] brk_addr,
    input  logic [QW-1:0] qual,
    input  logic          bus_valid,
    input  logic [AW-1:0] bus_addr,
    input  logic          bus_periph,
    input  logic          bus_fetch,
    input  logic          bus_write,
    input  logic          bus_wide,
    output logic          hit,
    output logic          hit_fetch,
    output logic [AW-1:0] hit_target
);
    logic who_ok, kind_ok, dir_ok, addr_ok;

    always_comb begin
        who_ok  = bus_periph ? qual[Q_PER]   : qual[Q_CPU];
        kind_ok = bus_fetch  ? qual[Q_FETCH] : qual[Q_DATA];
        dir_ok  = bus_write  ? qual[Q_WR]    : qual[Q_RD];
        if (!bus_fetch)
            addr_ok = (bus_addr == brk_addr);
        else if (bus_wide)
            addr_ok = (bus_addr[AW-1:2] == brk_addr[AW-1:2]);
        else
            addr_ok = (bus_addr[AW-1:1] == brk_addr[AW-1:1]);
        hit        = bus_valid && who_ok && kind_ok && dir_ok && addr_ok;
        hit_fetch  = bus_fetch;
        hit_target = bus_wide ? {bus_addr[AW-1:2], brk_addr[1], 1'b0}
                              : {bus_addr[AW-1:1], 1'b0};
    end
endmodule

// File: rtl/fbu_fsm.sv
module fbu_fsm
    import fbu_pkg::*;
#(
    parameter int AW = 32
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          hit,
    input  logic          hit_fetch,
    input  logic [AW-1:0] hit_target,
    input  logic          step_valid,
    input  logic [AW-1:0] step_pc,
    input  logic [AW-1:0] step_next_pc,
    input  logic          step_intr_ok,
    input  logic          brk_take,
    output logic          brk_req,
    output logic          brk_pend,
    output logic [AW-1:0] saved_pc
);
    fb_state_e     st_q, st_d;
    logic          fire, load_tgt;
    logic [AW-1:0] fire_pc, tgt_q;
    logic          at_tgt, can_take;

    assign at_tgt   = step_valid && (step_pc == tgt_q);
    assign can_take = step_valid && step_intr_ok;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= FB_IDLE;
        else        st_q <= st_d;
    end

    always_comb begin
        st_d     = st_q;
        fire     = 1'b0;
        fire_pc  = step_pc;
        load_tgt = 1'b0;
        unique case (st_q)
            FB_IDLE: begin
                if (hit) begin
                    st_d     = hit_fetch ? FB_ARMED : FB_DATAW;
                    load_tgt = hit_fetch;
                end
            end
            FB_ARMED: begin
                if (at_tgt) begin
                    if (step_intr_ok) begin
                        fire    = 1'b1;
                        fire_pc = tgt_q;
                        st_d    = FB_PEND;
                    end else begin
                        st_d    = FB_DEFER;
                    end
                end else if (hit && hit_fetch) begin
                    load_tgt = 1'b1;
                end
            end
            FB_DEFER: begin
                if (can_take) begin
                    fire    = 1'b1;
                    fire_pc = step_next_pc;
                    st_d    = FB_PEND;
                end
            end
            FB_DATAW: begin
                if (can_take) begin
                    fire    = 1'b1;
                    fire_pc = step_pc;
                    st_d    = FB_PEND;
                end
            end
            FB_PEND: begin
                if (brk_take) st_d = FB_IDLE;
            end
            default: st_d = FB_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            brk_req  <= 1'b0;
            saved_pc <= '0;
            tgt_q    <= '0;
        end else begin
            brk_req <= fire;
            if (fire)     saved_pc <= fire_pc;
            if (load_tgt) tgt_q    <= hit_target;
        end
    end

    assign brk_pend = (st_q == FB_PEND);
endmodule

// File: rtl/fetch_break_unit.sv
module fetch_break_unit
    import fbu_pkg::*;
#(
    parameter int AW = 32
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          cfg_we,
    input  logic [1:0]    cfg_sel,
    input  logic [AW/2-1:0] cfg_wdata,
    input  logic          bus_valid,
    input  logic [AW-1:0] bus_addr,
    input  logic          bus_periph,
    input  logic          bus_fetch,
    input  logic          bus_write,
    input  logic          bus_wide,
    input  logic          step_valid,
    input  logic [AW-1:0] step_pc,
    input  logic [AW-1:0] step_next_pc,
    input  logic          step_intr_ok,
    input  logic          brk_take,
    output logic          brk_req,
    output logic          brk_pend,
    output logic [AW-1:0] saved_pc
);
    logic [AW-1:0] brk_addr, hit_target;
    logic [QW-1:0] qual;
    logic          hit, hit_fetch;

    fbu_regs #(.AW(AW)) regs_i (
        .clk(clk), .rst_n(rst_n), .we(cfg_we), .sel(cfg_sel),
        .wdata(cfg_wdata), .brk_addr(brk_addr), .qual(qual)
    );

    fbu_match #(.AW(AW)) match_i (
        .brk_addr(brk_addr), .qual(qual), .bus_valid(bus_valid),
        .bus_addr(bus_addr), .bus_periph(bus_periph), .bus_fetch(bus_fetch),
        .bus_write(bus_write), .bus_wide(bus_wide), .hit(hit),
        .hit_fetch(hit_fetch), .hit_target(hit_target)
    );

    fbu_fsm #(.AW(AW)) fsm_i (
        .clk(clk), .rst_n(rst_n), .hit(hit), .hit_fetch(hit_fetch),
        .hit_target(hit_target), .step_valid(step_valid), .step_pc(step_pc),
        .step_next_pc(step_next_pc), .step_intr_ok(step_intr_ok),
        .brk_take(brk_take), .brk_req(brk_req), .brk_pend(brk_pend),
        .saved_pc(saved_pc)
    );
endmodule

// File: rtl/fbu_checker.sv
module fbu_checker #(
    parameter int AW = 32
) (
    input logic          clk,
    input logic          rst_n,
    input logic          brk_req,
    input logic          brk_pend,
    input logic          brk_take,
    input logic [AW-1:0] saved_pc
);
    assert_req_single_R9: assert property (@(posedge clk) disable iff (!rst_n)
        brk_req |=> !brk_req);

    assert_req_with_pend_R9: assert property (@(posedge clk) disable iff (!rst_n)
        brk_req |-> brk_pend);

    assert_pend_rise_req_R9: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(brk_pend) |-> brk_req);

    assert_pend_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (brk_pend && !brk_take) |=> brk_pend);

    assert_pend_clear_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (brk_pend && brk_take) |=> !brk_pend);

    assert_saved_stable_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (brk_pend && !brk_req) |-> $stable(saved_pc));
endmodule

bind fetch_break_unit fbu_checker #(.AW(AW)) chk_i (
    .clk(clk), .rst_n(rst_n), .brk_req(brk_req), .brk_pend(brk_pend),
    .brk_take(brk_take), .saved_pc(saved_pc)
);

// File: tb/fetch_break_unit_tb_top.sv
module fetch_break_unit_tb_top;
    localparam int CLK_P = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_we = 1'b0;
    logic [1:0]  cfg_sel = '0;
    logic [15:0] cfg_wdata = '0;
    logic        bus_valid = 1'b0;
    logic [31:0] bus_addr = '0;
    logic        bus_periph = 1'b0, bus_fetch = 1'b0, bus_write = 1'b0, bus_wide = 1'b0;
    logic        step_valid = 1'b0;
    logic [31:0] step_pc = '0, step_next_pc = '0;
    logic        step_intr_ok = 1'b0;
    logic        brk_take = 1'b0;
    logic        brk_req, brk_pend;
    logic [31:0] saved_pc;

    int n_chk = 0;
    int n_fail = 0;

    // reference model state
    int          m_st = 0;  // 0 idle 1 armed 2 defer 3 data 4 pend
    logic [31:0] m_addr = '0, m_tgt = '0, m_saved = '0;
    logic [5:0]  m_qual = '0;
    logic        m_req = 1'b0;

    always #(CLK_P/2) clk = ~clk;

    fetch_break_unit dut_i (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_sel(cfg_sel),
        .cfg_wdata(cfg_wdata), .bus_valid(bus_valid), .bus_addr(bus_addr),
        .bus_periph(bus_periph), .bus_fetch(bus_fetch), .bus_write(bus_write),
        .bus_wide(bus_wide), .step_valid(step_valid), .step_pc(step_pc),
        .step_next_pc(step_next_pc), .step_intr_ok(step_intr_ok),
        .brk_take(brk_take), .brk_req(brk_req), .brk_pend(brk_pend),
        .saved_pc(saved_pc)
    );

    task automatic chk(input logic ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic model_hit();
        logic who, kind, dir, adr;
        who  = bus_periph ? m_qual[1] : m_qual[0];
        kind = bus_fetch  ? m_qual[2] : m_qual[3];
        dir  = bus_write  ? m_qual[5] : m_qual[4];
        if (!bus_fetch)    adr = (bus_addr == m_addr);
        else if (bus_wide) adr = (bus_addr[31:2] == m_addr[31:2]);
        else               adr = (bus_addr[31:1] == m_addr[31:1]);
        return bus_valid && who && kind && dir && adr;
    endfunction

    function automatic logic [31:0] model_target();
        return bus_wide ? {bus_addr[31:2], m_addr[1], 1'b0} : {bus_addr[31:1], 1'b0};
    endfunction

    task automatic model_clk();
        logic h;
        h = model_hit();
        m_req = 1'b0;
        case (m_st)
            0: if (h) begin
                   m_st = bus_fetch ? 1 : 3;
                   if (bus_fetch) m_tgt = model_target();
               end
            1: if (step_valid && step_pc == m_tgt) begin
                   if (step_intr_ok) begin m_st = 4; m_req = 1'b1; m_saved = m_tgt; end
                   else m_st = 2;
               end else if (h && bus_fetch) m_tgt = model_target();
            2: if (step_valid && step_intr_ok) begin m_st = 4; m_req = 1'b1; m_saved = step_next_pc; end
            3: if (step_valid && step_intr_ok) begin m_st = 4; m_req = 1'b1; m_saved = step_pc; end
            4: if (brk_take) m_st = 0;
            default: m_st = 0;
        endcase
        if (cfg_we) begin
            case (cfg_sel)
                2'd0: m_addr[31:16] = cfg_wdata;
                2'd1: m_addr[15:0]  = cfg_wdata;
                2'd2: m_qual        = cfg_wdata[5:0];
                default: ;
            endcase
        end
    endtask

    task automatic tick();
        @(posedge clk);
        #1;
        model_clk();
        chk(brk_req == m_req, "R9 brk_req", {31'd0, brk_req}, {31'd0, m_req});
        chk(brk_pend == (m_st == 4), "R10 brk_pend", {31'd0, brk_pend}, {31'd0, m_st == 4});
        if (m_st == 4) chk(saved_pc == m_saved, "R6/R7/R8 saved_pc", saved_pc, m_saved);
        cfg_we = 1'b0; bus_valid = 1'b0; step_valid = 1'b0; brk_take = 1'b0;
    endtask

    task automatic wr(input logic [1:0] s, input logic [15:0] d);
        cfg_we = 1'b1; cfg_sel = s; cfg_wdata = d;
        tick();
    endtask

    task automatic set_brk(input logic [31:0] a, input logic [5:0] q);
        wr(2'd0, a[31:16]);
        wr(2'd1, a[15:0]);
        wr(2'd2, {10'd0, q});
    endtask

    task automatic bus(input logic [31:0] a, input logic per, input logic f, input logic w, input logic wide);
        bus_valid = 1'b1; bus_addr = a; bus_periph = per; bus_fetch = f;
        bus_write = w; bus_wide = wide;
        tick();
    endtask

    task automatic step(input logic [31:0] pc, input logic ok);
        step_valid = 1'b1; step_pc = pc; step_next_pc = pc + 32'd2; step_intr_ok = ok;
        tick();
    endtask

    task automatic take();
        brk_take = 1'b1;
        tick();
    endtask

    initial begin
        #(CLK_P * 150000);
        n_chk++; n_fail++;
        $display("FAIL watchdog expired");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        void'($urandom(32'd20240611));
        repeat (2) @(posedge clk);
        #1;
        // R1: reset state
        chk(brk_req == 1'b0 && brk_pend == 1'b0, "R1 reset flags", {30'd0, brk_req, brk_pend}, 32'd0);
        chk(saved_pc == 32'd0, "R1 reset saved_pc", saved_pc, 32'd0);
        rst_n = 1'b1;
        tick();
        // R1: qualifier cleared, matching address cannot break
        bus(32'h0, 1'b0, 1'b1, 1'b0, 1'b0);
        step(32'h0, 1'b1);
        tick();
        chk(brk_pend == 1'b0, "R1 no break with cleared qualifier", {31'd0, brk_pend}, 32'd0);

        // R2 R6 R9: narrow fetch break at 0x404, immediate
        set_brk(32'h0000_0404, 6'h15);
        bus(32'h0000_0404, 1'b0, 1'b1, 1'b0, 1'b0);
        step(32'h0000_0402, 1'b1);
        chk(brk_pend == 1'b0, "R6 no break on other pc", {31'd0, brk_pend}, 32'd0);
        step(32'h0000_0404, 1'b1);
        chk(brk_req == 1'b1, "R9 req after target step", {31'd0, brk_req}, 32'd1);
        chk(saved_pc == 32'h404, "R6 saved equals target", saved_pc, 32'h404);
        tick();
        chk(brk_req == 1'b0 && brk_pend == 1'b1, "R9 single pulse, R10 pend held", {30'd0, brk_req, brk_pend}, 32'd1);
        // R10 R11: hits while pending ignored
        bus(32'h0000_0404, 1'b0, 1'b1, 1'b0, 1'b0);
        step(32'h0000_0404, 1'b1);
        chk(saved_pc == 32'h404, "R11 saved stable while pending", saved_pc, 32'h404);
        take();
        chk(brk_pend == 1'b0, "R10 cleared by take", {31'd0, brk_pend}, 32'd0);
        // R10: take while idle has no effect
        take();
        bus(32'h0000_0404, 1'b0, 1'b1, 1'b0, 1'b0);
        step(32'h0000_0404, 1'b1);
        chk(brk_pend == 1'b1, "R10 idle take ignored, break still works", {31'd0, brk_pend}, 32'd1);
        take();

        // R4: wide fetch, second slot
        wr(2'd1, 16'h0402);
        bus(32'h0000_0400, 1'b0, 1'b1, 1'b0, 1'b1);
        step(32'h0000_0400, 1'b1);
        chk(brk_pend == 1'b0, "R4 first slot executes", {31'd0, brk_pend}, 32'd0);
        step(32'h0000_0402, 1'b1);
        chk(brk_pend == 1'b1 && saved_pc == 32'h402, "R4 second slot break", saved_pc, 32'h402);
        take();

        // R5: bit0 of break address ignored for narrow fetch
        wr(2'd1, 16'h0405);
        bus(32'h0000_0404, 1'b0, 1'b1, 1'b0, 1'b0);
        step(32'h0000_0404, 1'b1);
        chk(brk_pend == 1'b1 && saved_pc == 32'h404, "R5 bit0 ignored", saved_pc, 32'h404);
        take();

        // R7: deferred fetch break
        wr(2'd1, 16'h0404);
        bus(32'h0000_0404, 1'b0, 1'b1, 1'b0, 1'b0);
        step(32'h0000_0404, 1'b0);
        chk(brk_pend == 1'b0, "R7 blocked step executes", {31'd0, brk_pend}, 32'd0);
        step(32'h0000_0406, 1'b0);
        step(32'h0000_0408, 1'b1);
        chk(brk_pend == 1'b1 && saved_pc == 32'h40A, "R7 saved after accepting instr", saved_pc, 32'h40A);
        take();

        // R8 R3: data write break, CPU only
        set_brk(32'h0000_1000, 6'h29);
        bus(32'h0000_1000, 1'b0, 1'b0, 1'b0, 1'b0);
        bus(32'h0000_1000, 1'b1, 1'b0, 1'b1, 1'b0);
        step(32'h0000_0500, 1'b1);
        chk(brk_pend == 1'b0, "R3 read and peripheral do not hit", {31'd0, brk_pend}, 32'd0);
        bus(32'h0000_1000, 1'b0, 1'b0, 1'b1, 1'b0);
        step(32'h0000_0502, 1'b0);
        step(32'h0000_0504, 1'b1);
        chk(brk_pend == 1'b1 && saved_pc == 32'h504, "R8 data break saved pc", saved_pc, 32'h504);
        take();

        // random phase against the model (R3-R11)
        for (int blk = 0; blk < 12; blk++) begin
            set_brk(32'h0000_0400 + ($urandom_range(0, 7) * 2), 6'($urandom));
            for (int c = 0; c < 250; c++) begin
                if ($urandom_range(0, 2) == 0) begin
                    bus_valid = 1'b1;
                    bus_addr = 32'h0000_0400 + ($urandom_range(0, 7) * 2);
                    bus_periph = 1'($urandom); bus_fetch = 1'($urandom);
                    bus_write = 1'($urandom); bus_wide = 1'($urandom);
                end
                if ($urandom_range(0, 1) == 0) begin
                    step_valid = 1'b1;
                    step_pc = 32'h0000_0400 + ($urandom_range(0, 7) * 2);
                    step_next_pc = step_pc + 32'd2;
                    step_intr_ok = ($urandom_range(0, 3) != 0);
                end
                brk_take = ($urandom_range(0, 3) == 0);
                tick();
            end
        end

        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule